// File: doc/BRIEF.md
# Configurable-Format Serial Frame Transmitter

This block turns one parallel character into one asynchronous serial frame on a single output line. The frame is a low start bit, then the character bits with the least significant bit first, then a high stop bit. Control inputs choose a narrow or a wide character, an optional parity bit and the polarity of the line. A parity bit does not add a bit to the frame. It takes the place of the top character bit, so the frame length depends only on the width setting.

The block does not make its own bit timing. An external divider pulses `baud_tick` once per bit time, and the line changes only on those pulses. A character is handed over with a one-cycle `ld_valid` strobe while `busy` is low. A second request, `special_req`, sends a whole frame of idle (all mark) or break (all space) instead of a character. Controls are captured when a frame is accepted and are held for that frame.

Top module: `uart_tx_frame`

## Requirements
- R1: After reset `busy` is 0 and `tx_line` is 1 when `cfg_invert` is 0.
- R2: With `cfg_wide`=0 and `cfg_par_en`=0 a frame is 10 bits: a 0, then `ld_data[7:0]` with bit 0 first, then a 1.
- R3: With `cfg_wide`=1 a frame is 11 bits: a 0, then `ld_data[8:0]` with bit 0 first, then a 1.
- R4: With `cfg_par_en`=1 the top character bit (bit 7 when narrow, bit 8 when wide) is replaced by a parity bit over the lower character bits. `cfg_par_odd`=0 makes the count of ones in character plus parity even, and 1 makes it odd. Frame length is unchanged. When parity is disabled, `cfg_par_odd` has no effect.
- R5: With `cfg_invert`=1 every level on `tx_line` is inverted, including start, stop, idle-frame and break-frame bits. While `busy` is 0 the line rests at the inverse of `cfg_invert`.
- R6: `tx_line` changes only in the cycle after a `baud_tick` pulse. The first bit of a frame appears on the first tick after the frame is accepted.
- R7: `busy` is 1 from the cycle after acceptance. It falls on the tick that follows the stop bit's tick, so the stop bit is held for a full bit time.
- R8: `ld_valid` or `special_req` while `busy` is 1 is ignored. The frame in progress is unchanged and no further frame follows.
- R9: `special_req` with `special_kind`=0 sends a frame of all 1s, and with `special_kind`=1 a frame of all 0s. Its length is 10 or 11 bits as set by `cfg_wide`, and inversion applies.
- R10: If `ld_valid` and `special_req` arrive in the same idle cycle, the character is sent and the special request is dropped.
- R11: Control inputs changed after a frame is accepted do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| ld_valid | input | 1 | Character load strobe |
| ld_data | input | 9 | Character; bit 8 is used only in wide mode |
| special_req | input | 1 | Request an idle or break frame |
| special_kind | input | 1 | 0 selects an idle frame, 1 a break frame |
| cfg_wide | input | 1 | 0 selects an 8-bit character, 1 a 9-bit character |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Parity type: 0 even, 1 odd |
| cfg_invert | input | 1 | Invert every line level |
| tx_line | output | 1 | Serial output |
| busy | output | 1 | Frame accepted or in progress |

## Verification
The character load and the special-frame request can arrive in the same cycle. The bench raises both strobes together on one idle cycle, asking for a break alongside a character. It then requires the data frame bit for bit, followed by a line that stays idle with `busy` low over several more ticks. A second collision is a load arriving while a frame is in flight. The bench also changes every control input at that moment and requires the original frame to finish exactly as it was captured.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        KIND_DATA  = 2'd0,
        KIND_IDLE  = 2'd1,
        KIND_BREAK = 2'd2
    } tx_kind_e;

endpackage

// File: rtl/utx_parity.sv
module utx_parity #(
    parameter int W = 7
) (
    input  logic [W-1:0] bits_i,
    input  logic         odd_i,
    output logic         par_o
);
    logic [W:0] chain;

    assign chain[0] = odd_i;

    // Running XOR: the final stage balances the ones count to the chosen sense.
    for (genvar g = 0; g < W; g++) begin : g_xor
        assign chain[g+1] = chain[g] ^ bits_i[g];
    end

    assign par_o = chain[W];
endmodule

// File: rtl/utx_framer.sv
module utx_framer
    import uart_tx_pkg::*;
#(
    parameter int BASE_W  = 8,
    parameter int CHR_W   = BASE_W + 1,
    parameter int FRAME_W = BASE_W + 3,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [CHR_W-1:0]   data_i,
    input  logic               wide_i,
    input  logic               par_en_i,
    input  logic               par_odd_i,
    input  tx_kind_e           kind_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   len_o
);
    logic                par_narrow;
    logic                par_wide;
    logic [BASE_W-1:0]   chr_narrow;
    logic [CHR_W-1:0]    chr_wide;

    utx_parity #(.W(BASE_W - 1)) u_par_narrow (
        .bits_i (data_i[BASE_W-2:0]),
        .odd_i  (par_odd_i),
        .par_o  (par_narrow)
    );

    utx_parity #(.W(BASE_W)) u_par_wide (
        .bits_i (data_i[BASE_W-1:0]),
        .odd_i  (par_odd_i),
        .par_o  (par_wide)
    );

    always_comb begin
        chr_narrow = data_i[BASE_W-1:0];
        chr_wide   = data_i;
        if (par_en_i) begin
            chr_narrow[BASE_W-1] = par_narrow;
            chr_wide[CHR_W-1]    = par_wide;
        end
    end

    always_comb begin
        unique case (kind_i)
            KIND_IDLE:  frame_o = '1;
            KIND_BREAK: frame_o = '0;
            default: begin
                if (wide_i) frame_o = {1'b1, chr_wide, 1'b0};
                else        frame_o = {1'b1, 1'b1, chr_narrow, 1'b0};
            end
        endcase
        len_o = wide_i ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
    end
endmodule

// File: rtl/utx_seq.sv
module utx_seq
    import uart_tx_pkg::*;
#(
    parameter int FRAME_W = 11,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CNT_W-1:0]   len_i,
    input  logic               inv_i,
    output logic               busy_o,
    output logic               line_o,
    output logic               inv_o
);
    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic               line;
        logic               inv;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                seq_d.line = 1'b1;
                if (start_i) begin
                    seq_d.st  = ST_ARMED;
                    seq_d.sh  = frame_i;
                    seq_d.cnt = len_i;
                    seq_d.inv = inv_i;
                end
            end
            ST_ARMED: begin
                if (tick_i) begin
                    seq_d.st   = ST_SEND;
                    seq_d.line = seq_q.sh[0];
                    seq_d.sh   = {1'b1, seq_q.sh[FRAME_W-1:1]};
                    seq_d.cnt  = seq_q.cnt - 1'b1;
                end
            end
            default: begin
                if (tick_i) begin
                    if (seq_q.cnt == '0) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.line = 1'b1;
                    end else begin
                        seq_d.line = seq_q.sh[0];
                        seq_d.sh   = {1'b1, seq_q.sh[FRAME_W-1:1]};
                        seq_d.cnt  = seq_q.cnt - 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.sh   <= '1;
            seq_q.cnt  <= '0;
            seq_q.line <= 1'b1;
            seq_q.inv  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = (seq_q.st != ST_IDLE);
    assign line_o = seq_q.line;
    assign inv_o  = seq_q.inv;

    // R6
    line_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(seq_q.line));

    // R7
    busy_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(tick_i));

    // R8
    start_only_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R1
    idle_level_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> seq_q.line);
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
    import uart_tx_pkg::*;
#(
    parameter int BASE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              ld_valid,
    input  logic [BASE_W:0]   ld_data,
    input  logic              special_req,
    input  logic              special_kind,
    input  logic              cfg_wide,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_invert,
    output logic              tx_line,
    output logic              busy
);
    localparam int CHR_W   = BASE_W + 1;
    localparam int FRAME_W = BASE_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic               take_data;
    logic               take_special;
    logic               start;
    tx_kind_e           kind;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   len;
    logic               line_bit;
    logic               inv_held;

    // A character load takes precedence over a special request in the same cycle.
    assign take_data    = ld_valid & ~busy;
    assign take_special = special_req & ~busy & ~ld_valid;
    assign start        = take_data | take_special;

    always_comb begin
        if (take_data)         kind = KIND_DATA;
        else if (special_kind) kind = KIND_BREAK;
        else                   kind = KIND_IDLE;
    end

    utx_framer #(
        .BASE_W  (BASE_W),
        .CHR_W   (CHR_W),
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_framer (
        .data_i    (ld_data),
        .wide_i    (cfg_wide),
        .par_en_i  (cfg_par_en),
        .par_odd_i (cfg_par_odd),
        .kind_i    (kind),
        .frame_o   (frame),
        .len_o     (len)
    );

    utx_seq #(
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (baud_tick),
        .start_i (start),
        .frame_i (frame),
        .len_i   (len),
        .inv_i   (cfg_invert),
        .busy_o  (busy),
        .line_o  (line_bit),
        .inv_o   (inv_held)
    );

    assign tx_line = line_bit ^ (busy ? inv_held : cfg_invert);

    // R7
    busy_rise_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ld_valid || special_req));
endmodule

// File: tb/uart_tx_frame_bench.sv
module uart_tx_frame_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       ld_valid = 1'b0;
    logic [8:0] ld_data = '0;
    logic       special_req = 1'b0;
    logic       special_kind = 1'b0;
    logic       cfg_wide = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       tx_line;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_tx_frame u_uart_tx_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_tick    (baud_tick),
        .ld_valid     (ld_valid),
        .ld_data      (ld_data),
        .special_req  (special_req),
        .special_kind (special_kind),
        .cfg_wide     (cfg_wide),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_invert   (cfg_invert),
        .tx_line      (tx_line),
        .busy         (busy)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // kind: 0 data, 1 idle, 2 break
    function automatic logic exp_bit(int i, int kind, logic [8:0] d, logic w, logic pe, logic po);
        int  nb;
        logic p;
        if (kind == 1) return 1'b1;
        if (kind == 2) return 1'b0;
        nb = w ? 9 : 8;
        if (i == 0) return 1'b0;
        if (i == nb + 1) return 1'b1;
        if (pe && (i - 1 == nb - 1)) begin
            p = po;
            for (int j = 0; j < nb - 1; j++) p = p ^ d[j];
            return p;
        end
        return d[i-1];
    endfunction

    task automatic tick_once();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
    endtask

    task automatic idle_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // Accept a frame, then shift it out with checks on every bit.
    // disturb: at bit 3 pulse a load and flip all controls, restore at bit 5.
    task automatic run_frame(string req, int kind, logic [8:0] d, logic w, logic pe,
                             logic po, logic inv, bit both, bit disturb);
        int len;
        len = w ? 11 : 10;
        @(negedge clk);
        cfg_wide = w; cfg_par_en = pe; cfg_par_odd = po; cfg_invert = inv;
        ld_data = d;
        ld_valid = (kind == 0);
        special_req = (kind != 0) || both;
        special_kind = both ? 1'b1 : (kind == 2);
        @(negedge clk);
        ld_valid = 1'b0; special_req = 1'b0;
        check({req, " busy after accept"}, busy, 1);
        idle_cycles(3);
        check({req, " R6 no bit before tick"}, tx_line, !inv);
        for (int i = 0; i < len; i++) begin
            if (disturb && i == 3) begin
                @(negedge clk);
                ld_valid = 1'b1; ld_data = ~d; special_req = 1'b1;
                cfg_wide = !w; cfg_par_en = !pe; cfg_par_odd = !po; cfg_invert = !inv;
                @(negedge clk);
                ld_valid = 1'b0; special_req = 1'b0;
                check({req, " R8 line held"}, tx_line, exp_bit(i - 1, kind, d, w, pe, po) ^ inv);
            end
            if (disturb && i == 5) begin
                cfg_wide = w; cfg_par_en = pe; cfg_par_odd = po; cfg_invert = inv;
            end
            tick_once();
            check($sformatf("%s bit %0d", req, i), tx_line, exp_bit(i, kind, d, w, pe, po) ^ inv);
            check($sformatf("%s R7 busy bit %0d", req, i), busy, 1);
        end
        idle_cycles(2);
        check({req, " R7 stop held"}, busy, 1);
        tick_once();
        check({req, " R7 busy falls"}, busy, 0);
        check({req, " R5 idle level"}, tx_line, !inv);
    endtask

    task automatic t_reset();
        check("R1 busy at reset", busy, 0);
        check("R1 line at reset", tx_line, 1);
    endtask

    task automatic t_plain8();
        run_frame("R2 a5", 0, 9'h1A5, 0, 0, 0, 0, 0, 0);
        run_frame("R2 3c", 0, 9'h03C, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic t_nine();
        run_frame("R3 1a5", 0, 9'h1A5, 1, 0, 0, 0, 0, 0);
        run_frame("R3 0ff", 0, 9'h0FF, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_parity();
        run_frame("R4 even n", 0, 9'h083, 0, 1, 0, 0, 0, 0);
        run_frame("R4 odd n",  0, 9'h003, 0, 1, 1, 0, 0, 0);
        run_frame("R4 even w", 0, 9'h007, 1, 1, 0, 0, 0, 0);
        run_frame("R4 odd w",  0, 9'h1F7, 1, 1, 1, 0, 0, 0);
    endtask

    task automatic t_invert();
        @(negedge clk) cfg_invert = 1'b1;
        @(negedge clk);
        check("R5 idle inverted", tx_line, 0);
        run_frame("R5 inv", 0, 9'h05A, 0, 1, 1, 1, 0, 0);
        run_frame("R5 inv brk", 2, 9'h000, 1, 0, 0, 1, 0, 0);
        @(negedge clk) cfg_invert = 1'b0;
        @(negedge clk);
        check("R5 idle plain", tx_line, 1);
    endtask

    task automatic t_special();
        run_frame("R9 idle n",  1, 9'h000, 0, 0, 0, 0, 0, 0);
        run_frame("R9 break n", 2, 9'h000, 0, 0, 0, 0, 0, 0);
        run_frame("R9 break w", 2, 9'h000, 1, 0, 0, 0, 0, 0);
        run_frame("R9 idle inv", 1, 9'h000, 1, 0, 0, 1, 0, 0);
    endtask

    task automatic t_busy_ignore();
        run_frame("R8 R11 disturb", 0, 9'h0C9, 0, 1, 0, 0, 0, 1);
        for (int k = 0; k < 3; k++) begin
            tick_once();
            check("R8 no extra frame busy", busy, 0);
            check("R8 no extra frame line", tx_line, 1);
        end
    endtask

    task automatic t_both();
        run_frame("R10 collide", 0, 9'h096, 0, 0, 0, 0, 1, 0);
        for (int k = 0; k < 3; k++) begin
            tick_once();
            check("R10 special dropped busy", busy, 0);
            check("R10 special dropped line", tx_line, 1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle_cycles(2);
        t_reset();
        t_plain8();
        t_nine();
        t_parity();
        t_invert();
        t_special();
        t_busy_ignore();
        t_both();
        finish_run();
    end
endmodule